// File: doc/BRIEF.md
# Parallel ROM read controller

This block fetches single bytes from a bank of external asynchronous read-only memories. A host raises a request with a flat address and holds it until the block pulses an acknowledge together with the fetched byte. The upper address bits choose one of several devices. The lower bits go to the shared device address bus.

On the device side the block drives the address, one active-low select per device and one active-low output strobe shared by every device. The selects are a one-hot decode of the bank. All devices that are not addressed keep their select high, so they stay in standby. The block does not know the ROM's internals. It only respects three delays, given in nanoseconds and turned into whole clock cycles: address/select access time, strobe access time and output float time. The strobe is raised late enough that its own access time ends in the same cycle as the address access time. When the next read targets a different device, its select waits until the previous device has had time to release the data bus.

Top module: `rom_rd_ctrl`

## Requirements
- R1: Out of reset every select is high, the output strobe is high and the acknowledge is low.
- R2: A request is taken only while the block is idle. The host keeps the request and address stable until the acknowledge. The acknowledge is high for exactly one cycle, and `rdata_o` holds the fetched byte in that cycle.
- R3: The bank index is `req_addr_i[HOST_AW-1:DEV_AW]`. Only the select bit with that index goes low, and never more than one select is low. `rom_addr_o` carries `req_addr_i[DEV_AW-1:0]`.
- R4: While a select stays low, the device address does not change.
- R5: Each delay in cycles is max(1, ceil(ns / CLK_NS)). The strobe cycle count is clamped to the access count. The strobe goes low exactly (access cycles − strobe cycles) clock cycles after the select goes low.
- R6: The data bus is captured on the clock edge that falls access-cycles after the select went low. The select and strobe rise on that same edge, and the acknowledge is high in the following cycle.
- R7: When a read targets a different bank from the previous read, its select goes low no sooner than float-cycles after the previous strobe rose. If the request is already waiting, the select goes low exactly then (or two cycles after the rise, whichever is later).
- R8: A read to the same bank as the previous read does not wait for float time. With the request waiting, its select goes low two cycles after the previous strobe rose.
- R9: The strobe is low only while some select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host read request, held until acknowledge |
| req_addr_i | input | HOST_AW | Host byte address: bank index above device address |
| ack_o | output | 1 | One-cycle read completion pulse |
| rdata_o | output | DATA_W | Fetched byte, valid with ack_o |
| rom_addr_o | output | DEV_AW | Shared device address bus |
| rom_sel_n_o | output | BANKS | Active-low one-hot device selects |
| rom_oe_n_o | output | 1 | Active-low shared output strobe |
| rom_data_i | input | DATA_W | Device data bus |

## Verification
The case of interest is a new request that is already waiting when the float countdown of the previous read expires, so the bank decode and the bus-release timer act on the same edge. The bench provokes it by issuing each read in the cycle right after the previous acknowledge and alternating between same-bank and cross-bank targets. The float time is longer than the two-cycle idle gap, so the two cases give different gaps. The bench judges the result by the exact cycle distance from strobe release to the new select: two cycles for the same bank, the float count for a new bank. A device model returns corrupted data whenever the access windows were not met, so that one check covers both the read data and the strobe placement.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_ACK    = 2'd2
    } rd_state_e;

    // whole clock cycles covering a delay, never less than one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_rd_bank_dec.sv
module rom_rd_bank_dec #(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned BANK_W = 2
) (
    input  logic              en,
    input  logic [BANK_W-1:0] bank,
    output logic [BANKS-1:0]  sel_n
);
    for (genvar g = 0; g < BANKS; g++) begin : g_sel
        assign sel_n[g] = !(en && (bank == BANK_W'(g)));
    end
endmodule

// File: rtl/rom_rd_access_timer.sv
module rom_rd_access_timer #(
    parameter int unsigned ACC_CYC  = 4,
    parameter int unsigned LEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic strobe_hit,
    output logic sample_hit
);
    localparam int unsigned CNT_W = $clog2(ACC_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign sample_hit = run && (cnt_q == CNT_W'(ACC_CYC));

    if (LEAD_CYC == 0) begin : g_no_lead
        assign strobe_hit = 1'b0;
    end else begin : g_lead
        assign strobe_hit = run && (cnt_q == CNT_W'(LEAD_CYC));
    end

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(1);
        end else if (run) begin
            cnt_d = sample_hit ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rom_rd_float_timer.sv
module rom_rd_float_timer #(
    parameter int unsigned DF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    output logic bus_free
);
    localparam int unsigned CNT_W = $clog2(DF_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // an edge is allowed to enable a new bank when at most one cycle remains
    assign bus_free = (cnt_q <= CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (release_i)           cnt_d = CNT_W'(DF_CYC);
        else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DEV_AW    = 18,
    parameter int unsigned BANKS     = 4,
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned T_ACC_NS  = 70,
    parameter int unsigned T_OE_NS   = 35,
    parameter int unsigned T_DF_NS   = 30,
    localparam int unsigned BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int unsigned HOST_AW  = DEV_AW + BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [HOST_AW-1:0] req_addr_i,
    output logic               ack_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [DEV_AW-1:0]  rom_addr_o,
    output logic [BANKS-1:0]   rom_sel_n_o,
    output logic               rom_oe_n_o,
    input  logic [DATA_W-1:0]  rom_data_i
);
    localparam int unsigned ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned OE_CYC   = min_u(ns_to_cyc(T_OE_NS, CLK_NS), ACC_CYC);
    localparam int unsigned LEAD_CYC = ACC_CYC - OE_CYC;
    localparam int unsigned DF_CYC   = ns_to_cyc(T_DF_NS, CLK_NS);

    typedef struct packed {
        rd_state_e          st;
        logic [DEV_AW-1:0]  addr;
        logic [BANK_W-1:0]  bank;
        logic [BANK_W-1:0]  last_bank;
        logic               sel_en;
        logic               oe;
        logic               ack;
        logic [DATA_W-1:0]  rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              start;
    logic              strobe_hit;
    logic              sample_hit;
    logic              bus_free;
    logic [BANK_W-1:0] req_bank;
    logic [DEV_AW-1:0] req_dev;

    if (BANKS > 1) begin : g_multi
        assign req_bank = req_addr_i[HOST_AW-1:DEV_AW];
    end else begin : g_single
        assign req_bank = '0;
    end
    assign req_dev = req_addr_i[DEV_AW-1:0];

    assign start = (ctl_q.st == ST_IDLE) && req_i &&
                   ((req_bank == ctl_q.last_bank) || bus_free);

    rom_rd_access_timer #(
        .ACC_CYC  (ACC_CYC),
        .LEAD_CYC (LEAD_CYC)
    ) i_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (ctl_q.st == ST_ACCESS),
        .strobe_hit (strobe_hit),
        .sample_hit (sample_hit)
    );

    rom_rd_float_timer #(
        .DF_CYC (DF_CYC)
    ) i_float (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (sample_hit),
        .bus_free  (bus_free)
    );

    rom_rd_bank_dec #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W)
    ) i_dec (
        .en    (ctl_q.sel_en),
        .bank  (ctl_q.bank),
        .sel_n (rom_sel_n_o)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st        = ST_ACCESS;
                    ctl_d.addr      = req_dev;
                    ctl_d.bank      = req_bank;
                    ctl_d.last_bank = req_bank;
                    ctl_d.sel_en    = 1'b1;
                    ctl_d.oe        = (LEAD_CYC == 0);
                end
            end
            ST_ACCESS: begin
                if (strobe_hit) ctl_d.oe = 1'b1;
                if (sample_hit) begin
                    ctl_d.rdata  = rom_data_i;
                    ctl_d.ack    = 1'b1;
                    ctl_d.sel_en = 1'b0;
                    ctl_d.oe     = 1'b0;
                    ctl_d.st     = ST_ACK;
                end
            end
            ST_ACK:  ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, bank: '0, last_bank: '0,
                       sel_en: 1'b0, oe: 1'b0, ack: 1'b0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ack_o      = ctl_q.ack;
    assign rdata_o    = ctl_q.rdata;
    assign rom_addr_o = ctl_q.addr;
    assign rom_oe_n_o = !ctl_q.oe;
endmodule

// File: rtl/rom_rd_ctrl_chk.sv
module rom_rd_ctrl_chk #(
    parameter int unsigned BANKS    = 4,
    parameter int unsigned DEV_AW   = 18,
    parameter int unsigned ACC_CYC  = 4,
    parameter int unsigned LEAD_CYC = 2,
    parameter int unsigned DF_CYC   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANKS-1:0]  sel_n,
    input logic              oe_n,
    input logic [DEV_AW-1:0] addr,
    input logic              ack
);
    localparam int unsigned MAXC = ACC_CYC + DF_CYC + 2;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic [CW-1:0]    age_q;
    logic [CW-1:0]    gap_q;
    logic             prev_oe_n_q;
    logic [BANKS-1:0] last_sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q       <= '0;
            gap_q       <= CW'(MAXC);
            prev_oe_n_q <= 1'b1;
            last_sel_q  <= '1;
        end else begin
            prev_oe_n_q <= oe_n;
            if (&sel_n)                  age_q <= '0;
            else if (age_q != CW'(MAXC)) age_q <= age_q + CW'(1);
            if (oe_n && !prev_oe_n_q)    gap_q <= CW'(1);
            else if (gap_q != CW'(MAXC)) gap_q <= gap_q + CW'(1);
            if (!(&sel_n))               last_sel_q <= sel_n;
        end
    end

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sel_n) && $stable(sel_n)) |-> $stable(addr));

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_strobe_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> (age_q == CW'(LEAD_CYC)));

    assert_sample_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> (age_q == CW'(ACC_CYC)));

    assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&sel_n) && (&$past(sel_n)) && (sel_n != last_sel_q) && !(&last_sel_q))
        |-> (gap_q >= CW'(DF_CYC)));

    assert_strobe_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !(&sel_n));
endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
    .BANKS    (BANKS),
    .DEV_AW   (DEV_AW),
    .ACC_CYC  (ACC_CYC),
    .LEAD_CYC (LEAD_CYC),
    .DF_CYC   (DF_CYC)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (rom_sel_n_o),
    .oe_n  (rom_oe_n_o),
    .addr  (rom_addr_o),
    .ack   (ack_o)
);

// File: tb/test_rom_rd_ctrl.sv
module test_rom_rd_ctrl;
    localparam int DATA_W = 8;
    localparam int DEV_AW = 8;
    localparam int BANKS  = 4;
    localparam int BANK_W = 2;
    localparam int HOST_AW = DEV_AW + BANK_W;
    localparam int CLKP   = 20;
    localparam int ACC_NS = 90;
    localparam int OE_NS  = 40;
    localparam int DF_NS  = 90;

    function automatic int to_cyc(input int ns);
        int c;
        c = (ns + CLKP - 1) / CLKP;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int ACC_C  = to_cyc(ACC_NS);
    localparam int OE_C   = (to_cyc(OE_NS) < ACC_C) ? to_cyc(OE_NS) : ACC_C;
    localparam int LEAD_C = ACC_C - OE_C;
    localparam int DF_C   = to_cyc(DF_NS);

    function automatic logic [7:0] rom_byte(input int b, input int a);
        return 8'((a * 7) ^ (b * 61) ^ 8'h3C);
    endfunction

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req = 1'b0;
    logic [HOST_AW-1:0] req_addr = '0;
    logic               ack;
    logic [DATA_W-1:0]  rdata;
    logic [DEV_AW-1:0]  rom_addr;
    logic [BANKS-1:0]   sel_n;
    logic               oe_n;
    logic [DATA_W-1:0]  rom_data = '0;

    always #10 clk = ~clk;

    rom_rd_ctrl #(
        .DATA_W(DATA_W), .DEV_AW(DEV_AW), .BANKS(BANKS), .CLK_NS(CLKP),
        .T_ACC_NS(ACC_NS), .T_OE_NS(OE_NS), .T_DF_NS(DF_NS)
    ) i_rom_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
        .ack_o(ack), .rdata_o(rdata), .rom_addr_o(rom_addr),
        .rom_sel_n_o(sel_n), .rom_oe_n_o(oe_n), .rom_data_i(rom_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0] bank;
        logic [7:0] addr;
        logic [7:0] data;
    } exp_t;
    exp_t sb[$];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // device model and monitor
    logic [BANKS-1:0]  prev_sel = '1;
    logic              prev_oe  = 1'b1;
    logic              prev_ack = 1'b0;
    logic [BANKS-1:0]  m_sel = '1;
    logic [DEV_AW-1:0] m_addr = '0;
    int sel_age = 0, oe_age = 0;
    int sel_cyc = 0, rel_cyc = 0, rel_bank = -1, cur_bank = 0;
    bit addr_moved = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int b;
            b = -1;
            for (int i = 0; i < BANKS; i++) if (!sel_n[i]) b = i;
            // model: data valid only once every access window is met
            if (!(&sel_n) && sel_n == m_sel && rom_addr == m_addr) sel_age++;
            else sel_age = (&sel_n) ? 0 : 1;
            if (!oe_n) oe_age++; else oe_age = 0;
            m_sel  = sel_n;
            m_addr = rom_addr;
            if (b >= 0 && sel_age >= ACC_C && oe_age >= OE_C)
                rom_data = rom_byte(b, int'(rom_addr));
            else
                rom_data = ~rom_byte((b < 0) ? 0 : b, int'(rom_addr));

            if (prev_ack) check(!ack, "R2 ack single cycle", int'(ack), 0);

            if ((&prev_sel) && !(&sel_n)) begin
                check($countones(~sel_n) == 1, "R3 one select low", $countones(~sel_n), 1);
                if (sb.size() > 0) begin
                    check(b == int'(sb[0].bank), "R3 bank decode", b, int'(sb[0].bank));
                    check(rom_addr == sb[0].addr, "R3 device address", int'(rom_addr), int'(sb[0].addr));
                end
                if (rel_bank >= 0) begin
                    if (b == rel_bank)
                        check(cyc - rel_cyc == 2, "R8 same bank gap", cyc - rel_cyc, 2);
                    else
                        check(cyc - rel_cyc == ((DF_C > 2) ? DF_C : 2), "R7 float gap",
                              cyc - rel_cyc, (DF_C > 2) ? DF_C : 2);
                end
                sel_cyc    = cyc;
                cur_bank   = b;
                addr_moved = 0;
            end else if (!(&sel_n) && rom_addr != m_addr) begin
                addr_moved = 1;
            end
            if (!oe_n && prev_oe) begin
                check(cyc - sel_cyc == LEAD_C, "R5 strobe lead", cyc - sel_cyc, LEAD_C);
                check(!(&sel_n), "R9 strobe with select", int'(&sel_n), 0);
            end
            if (oe_n && !prev_oe) begin
                rel_cyc  = cyc;
                rel_bank = cur_bank;
                check(&sel_n, "R6 select released with strobe", int'(sel_n), (1 << BANKS) - 1);
            end
            if (ack && !prev_ack) begin
                check(cyc - sel_cyc == ACC_C, "R6 sample point", cyc - sel_cyc, ACC_C);
                check(!addr_moved, "R4 address held", int'(addr_moved), 0);
                if (sb.size() > 0) begin
                    check(rdata == sb[0].data, "R2 read data", int'(rdata), int'(sb[0].data));
                    void'(sb.pop_front());
                end else begin
                    check(0, "R2 unexpected ack", 1, 0);
                end
            end
            prev_sel = sel_n;
            prev_oe  = oe_n;
            prev_ack = ack;
        end
    end

    task automatic do_read(input int b, input int a);
        exp_t e;
        e.bank = 8'(b);
        e.addr = 8'(a);
        e.data = rom_byte(b, a);
        sb.push_back(e);
        @(negedge clk);
        req      = 1'b1;
        req_addr = {BANK_W'(b), DEV_AW'(a)};
        do @(negedge clk); while (!ack);
        req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(&sel_n, "R1 selects high in reset", int'(sel_n), (1 << BANKS) - 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(&sel_n, "R1 selects high after reset", int'(sel_n), (1 << BANKS) - 1);
        check(oe_n == 1'b1, "R1 strobe high", int'(oe_n), 1);
        check(ack == 1'b0, "R1 ack low", int'(ack), 0);
        do_read(0, 8'h12);
        do_read(0, 8'h34);
        do_read(1, 8'h34);
        do_read(1, 8'hFF);
        do_read(3, 8'h00);
        do_read(2, 8'h80);
        do_read(2, 8'h81);
        do_read(0, 8'h55);
        do_read(3, 8'hA7);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 all reads acknowledged", sb.size(), 0);
        check(&sel_n && oe_n, "R1 idle bus after reads", int'(sel_n), (1 << BANKS) - 1);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end
endmodule